// File: doc/BRIEF.md
# Indexed Control Register Window with Auto-Step

This block gives a host sixteen byte-wide controller registers through a two-port window: a 4-bit index register selects the register, and a data port reads or writes it. After most accesses the index moves to the next register on its own, so a host can stream through a run of registers with one index load. The registers seen on a read are not the ones reached by a write at the same index. Reads expose command input, interface status, byte count, header, pointer, write address and status bytes. Writes reach subheader out, interface control, byte count, DMA address, control bytes, pointer and write address, plus four action slots: transfer trigger, transfer acknowledge, the third control byte and a soft reset.

Beyond plain storage, the block applies the flag side effects of these accesses. These are starting and stopping a transfer, clearing interrupt flags, and a decode-status interlock. The interlock re-arms the last status byte only after the host has read a fixed set of registers. Read data is combinational from the current index. The index step and every side effect take place on the clock edge that samples the strobe.

Top module: `sector_ctl_regfile`

## Requirements
- R1: After reset the index is 0. Reads by index are: 1 gives 0xFF; 7 gives 0x01; 10 gives 0x60; 11 gives 0x12; 12 gives 0x80; every other index gives 0x00. The outputs `xfer_active`, `dma_addr`, `sub_hdr`, `ctl_word` and `ifctl_out` are zero.
- R2: A read strobe at index N (N below 15) leaves the index at N+1 on the next cycle. A read at index 15 leaves the index at 15.
- R3: A write strobe at index N leaves the index at N+1 on the next cycle. Writes at 6, 7, 14 and 15 are the exception and leave the index unchanged.
- R4: An `addr_ld` pulse loads `addr_in` into the index on the next cycle. A strobe in the same cycle acts on the old index.
- R5: Read map: 0 command input; 1 interface status; 2 and 3 byte count low and high; 4 to 7 header bytes 0 to 3; 8 and 9 pointer low and high; 10 and 11 write address low and high; 12 to 15 status bytes 0 to 3. Write map: 2 and 3 byte count; 8 and 9 write address; 12 and 13 pointer. All values are little-endian byte pairs.
- R6: A write to index 1 stores interface control. If bit 1 of the written byte is 0, the byte count becomes 0, `xfer_active` falls and interface status bit 3 is set.
- R7: A write to index 6 while interface control bit 1 is set raises `xfer_start` in that cycle, sets `xfer_active` and clears interface status bit 3. With bit 1 clear, the write has no effect.
- R8: A write to index 7 sets interface status bit 6 and holds the index.
- R9: A read of any of the indexes 1, 4 to 9 and 12 to 14 marks that index in a tracking mask. A read of index 15 sets interface status bit 5.
- R10: A read of index 15 returns the old status byte 3. Afterwards that byte becomes 0x80, but only when control byte 0 bit 7 and interface control bit 5 are set and every index listed in R9 has been marked.
- R11: A write to index 15 restores the R1 register values and clears the tracking mask, `xfer_active` and all written registers. The index stays at 15.
- R12: Writes to 0, 4/5, 10, 11 and 14 appear on `sub_hdr`, `dma_addr` (low, high), and `ctl_word` as {control 2, control 1, control 0}. Interface control appears on `ifctl_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_ld | input | 1 | Load the index from addr_in |
| addr_in | input | 4 | New index value |
| rd_stb | input | 1 | Read strobe for the register at the current index |
| wr_stb | input | 1 | Write strobe for the register at the current index |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read-side register at the current index |
| addr_cur | output | 4 | Current index |
| xfer_active | output | 1 | Transfer in progress |
| xfer_start | output | 1 | Start pulse during an enabled trigger write |
| dma_addr | output | 16 | DMA address register |
| sub_hdr | output | 8 | Subheader out byte |
| ctl_word | output | 24 | Control bytes 2, 1, 0 |
| ifctl_out | output | 8 | Interface control byte |

## Verification
The assertions assume that the read and write strobes never rise in the same cycle. The index-step properties apply only in cycles without an index load, because a load overrides the step. The stimulus keeps to this by running each access, load, read or write, as a single-cycle pulse followed by an idle cycle, so no two actions overlap. Random sequences, soft resets included, are mixed with directed runs through the interlock, which leave exactly one tracked register unread and then complete the set.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int AW   = 4;
  localparam int DW   = 8;
  localparam int NREG = 1 << AW;

  typedef logic [AW-1:0] ra_t;
  typedef logic [DW-1:0] byte_t;

  // write-side indices
  localparam ra_t W_SUBHDR = 4'd0,  W_IFCTL  = 4'd1,  W_CNT_LO = 4'd2,  W_CNT_HI = 4'd3;
  localparam ra_t W_DMA_LO = 4'd4,  W_DMA_HI = 4'd5,  W_TRIG   = 4'd6,  W_ACK    = 4'd7;
  localparam ra_t W_WA_LO  = 4'd8,  W_WA_HI  = 4'd9,  W_CTL0   = 4'd10, W_CTL1   = 4'd11;
  localparam ra_t W_PTR_LO = 4'd12, W_PTR_HI = 4'd13, W_CTL2   = 4'd14, W_SRST   = 4'd15;

  // read-side indices
  localparam ra_t RD_CMD   = 4'd0,  RD_IFST  = 4'd1,  RD_CNT_LO = 4'd2, RD_CNT_HI = 4'd3;
  localparam ra_t RD_HDR0  = 4'd4,  RD_PTR_LO = 4'd8, RD_PTR_HI = 4'd9;
  localparam ra_t RD_WA_LO = 4'd10, RD_WA_HI = 4'd11, RD_ST0    = 4'd12, RD_ST3    = 4'd15;

  // flag bit positions
  localparam int IFS_IDLE  = 3;
  localparam int IFS_DEC_N = 5;
  localparam int IFS_END_N = 6;
  localparam int IFC_XEN   = 1;
  localparam int IFC_DECIE = 5;
  localparam int CTL0_DEC  = 7;
endpackage

// File: rtl/sctl_addr_step.sv
module sctl_addr_step
  import sctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ld,
  input  ra_t  ld_val,
  input  logic rd_go,
  input  logic wr_go,
  output ra_t  addr
);
  logic step;
  logic en;
  ra_t  addr_d;

  function automatic logic wr_holds(input ra_t a);
    return (a == W_TRIG) || (a == W_ACK) || (a == W_CTL2) || (a == W_SRST);
  endfunction

  always_comb begin
    step = 1'b0;
    if (wr_go)      step = !wr_holds(addr);
    else if (rd_go) step = (addr != ra_t'(NREG - 1));
    en     = ld | step;
    addr_d = addr;
    if (ld)        addr_d = ld_val;
    else if (step) addr_d = addr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  addr <= '0;
    else if (en) addr <= addr_d;
  end
endmodule

// File: rtl/sctl_core.sv
module sctl_core
  import sctl_pkg::*;
#(
  parameter logic [15:0] WA_INIT   = 16'd4704,
  parameter logic [31:0] HEAD_INIT = 32'h0100_0000,
  parameter logic [31:0] STAT_INIT = 32'h0000_0080,
  parameter byte_t       IFST_INIT = 8'hFF,
  parameter logic [NREG-1:0] TRACK = 16'h73F2,
  parameter byte_t       ARMED     = 8'h80
) (
  input  logic clk,
  input  logic rst_n,
  input  ra_t  cur,
  input  logic rd_go,
  input  logic wr_go,
  input  byte_t wdata,
  output logic [NREG-1:0][DW-1:0] rd_bank,
  output logic xfer_active,
  output logic xfer_start,
  output logic [2*DW-1:0] dma_addr,
  output byte_t sub_hdr,
  output logic [3*DW-1:0] ctl_word,
  output byte_t ifctl_out
);
  byte_t comin_q, ifst_q, ifst_d, ifctl_q, ifctl_d, sbo_q, sbo_d;
  byte_t ctl0_q, ctl0_d, ctl1_q, ctl1_d, ctl2_q, ctl2_d;
  logic [2*DW-1:0] dbc_q, dbc_d, dac_q, dac_d, wa_q, wa_d, pt_q, pt_d;
  logic [3:0][DW-1:0] head_q, stat_q, stat_d;
  logic [NREG-1:0] mask_q, mask_d;
  logic act_q, act_d;
  logic en;

  assign en         = rd_go | wr_go;
  assign xfer_start = wr_go && (cur == W_TRIG) && ifctl_q[IFC_XEN];

  always_comb begin
    ifst_d = ifst_q;  ifctl_d = ifctl_q; sbo_d = sbo_q;
    ctl0_d = ctl0_q;  ctl1_d = ctl1_q;   ctl2_d = ctl2_q;
    dbc_d  = dbc_q;   dac_d  = dac_q;    wa_d   = wa_q;  pt_d = pt_q;
    stat_d = stat_q;  mask_d = mask_q;   act_d  = act_q;
    if (wr_go) begin
      unique case (cur)
        W_SUBHDR: sbo_d = wdata;
        W_IFCTL: begin
          ifctl_d = wdata;
          if (!wdata[IFC_XEN]) begin
            dbc_d = '0;
            act_d = 1'b0;
            ifst_d[IFS_IDLE] = 1'b1;
          end
        end
        W_CNT_LO: dbc_d[DW-1:0]    = wdata;
        W_CNT_HI: dbc_d[2*DW-1:DW] = wdata;
        W_DMA_LO: dac_d[DW-1:0]    = wdata;
        W_DMA_HI: dac_d[2*DW-1:DW] = wdata;
        W_TRIG: begin
          if (ifctl_q[IFC_XEN]) begin
            ifst_d[IFS_IDLE] = 1'b0;
            act_d = 1'b1;
          end
        end
        W_ACK:    ifst_d[IFS_END_N] = 1'b1;
        W_WA_LO:  wa_d[DW-1:0]    = wdata;
        W_WA_HI:  wa_d[2*DW-1:DW] = wdata;
        W_CTL0:   ctl0_d = wdata;
        W_CTL1:   ctl1_d = wdata;
        W_PTR_LO: pt_d[DW-1:0]    = wdata;
        W_PTR_HI: pt_d[2*DW-1:DW] = wdata;
        W_CTL2:   ctl2_d = wdata;
        W_SRST: begin
          ifst_d = IFST_INIT; ifctl_d = '0; sbo_d = '0;
          ctl0_d = '0; ctl1_d = '0; ctl2_d = '0;
          dbc_d  = '0; dac_d  = '0; wa_d = WA_INIT; pt_d = '0;
          stat_d = STAT_INIT; mask_d = '0; act_d = 1'b0;
        end
        default: ;
      endcase
    end else if (rd_go) begin
      if (TRACK[cur]) mask_d[cur] = 1'b1;
      if (cur == RD_ST3) begin
        ifst_d[IFS_DEC_N] = 1'b1;
        if (ctl0_q[CTL0_DEC] && ifctl_q[IFC_DECIE] && ((mask_q & TRACK) == TRACK))
          stat_d[3] = ARMED;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comin_q <= '0; head_q <= HEAD_INIT;
      ifst_q <= IFST_INIT; ifctl_q <= '0; sbo_q <= '0;
      ctl0_q <= '0; ctl1_q <= '0; ctl2_q <= '0;
      dbc_q  <= '0; dac_q  <= '0; wa_q <= WA_INIT; pt_q <= '0;
      stat_q <= STAT_INIT; mask_q <= '0; act_q <= 1'b0;
    end else if (en) begin
      ifst_q <= ifst_d; ifctl_q <= ifctl_d; sbo_q <= sbo_d;
      ctl0_q <= ctl0_d; ctl1_q <= ctl1_d; ctl2_q <= ctl2_d;
      dbc_q  <= dbc_d;  dac_q  <= dac_d;  wa_q <= wa_d; pt_q <= pt_d;
      stat_q <= stat_d; mask_q <= mask_d; act_q <= act_d;
    end
  end

  always_comb begin
    rd_bank            = '0;
    rd_bank[RD_CMD]    = comin_q;
    rd_bank[RD_IFST]   = ifst_q;
    rd_bank[RD_CNT_LO] = dbc_q[DW-1:0];
    rd_bank[RD_CNT_HI] = dbc_q[2*DW-1:DW];
    rd_bank[RD_PTR_LO] = pt_q[DW-1:0];
    rd_bank[RD_PTR_HI] = pt_q[2*DW-1:DW];
    rd_bank[RD_WA_LO]  = wa_q[DW-1:0];
    rd_bank[RD_WA_HI]  = wa_q[2*DW-1:DW];
    for (int i = 0; i < 4; i++) begin
      rd_bank[int'(RD_HDR0) + i] = head_q[i];
      rd_bank[int'(RD_ST0) + i]  = stat_q[i];
    end
  end

  assign xfer_active = act_q;
  assign dma_addr    = dac_q;
  assign sub_hdr     = sbo_q;
  assign ctl_word    = {ctl2_q, ctl1_q, ctl0_q};
  assign ifctl_out   = ifctl_q;
endmodule

// File: rtl/sctl_rd_mux.sv
module sctl_rd_mux
  import sctl_pkg::*;
(
  input  logic [NREG-1:0][DW-1:0] bank,
  input  ra_t   sel,
  output byte_t q
);
  assign q = bank[sel];
endmodule

// File: rtl/sector_ctl_regfile.sv
module sector_ctl_regfile
  import sctl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                addr_ld,
  input  logic [AW-1:0]       addr_in,
  input  logic                rd_stb,
  input  logic                wr_stb,
  input  logic [DW-1:0]       wr_data,
  output logic [DW-1:0]       rd_data,
  output logic [AW-1:0]       addr_cur,
  output logic                xfer_active,
  output logic                xfer_start,
  output logic [2*DW-1:0]     dma_addr,
  output logic [DW-1:0]       sub_hdr,
  output logic [3*DW-1:0]     ctl_word,
  output logic [DW-1:0]       ifctl_out
);
  logic wr_go, rd_go;
  logic [NREG-1:0][DW-1:0] bank;

  // a write wins over a coincident read
  assign wr_go = wr_stb;
  assign rd_go = rd_stb & ~wr_stb;

  sctl_addr_step u_step (
    .clk(clk), .rst_n(rst_n), .ld(addr_ld), .ld_val(addr_in),
    .rd_go(rd_go), .wr_go(wr_go), .addr(addr_cur)
  );

  sctl_core u_core (
    .clk(clk), .rst_n(rst_n), .cur(addr_cur), .rd_go(rd_go), .wr_go(wr_go),
    .wdata(wr_data), .rd_bank(bank), .xfer_active(xfer_active),
    .xfer_start(xfer_start), .dma_addr(dma_addr), .sub_hdr(sub_hdr),
    .ctl_word(ctl_word), .ifctl_out(ifctl_out)
  );

  sctl_rd_mux u_mux (.bank(bank), .sel(addr_cur), .q(rd_data));
endmodule

// File: rtl/sctl_chk.sv
module sctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       addr_ld,
  input logic [3:0] addr_in,
  input logic       rd_stb,
  input logic       wr_stb,
  input logic       wd_xen,
  input logic [3:0] addr_cur,
  input logic       xfer_active,
  input logic       xfer_start,
  input logic [7:0] ifctl_out
);
  logic wr_hold;
  assign wr_hold = (addr_cur == 4'd6) || (addr_cur == 4'd7) ||
                   (addr_cur == 4'd14) || (addr_cur == 4'd15);

  // R2 input contract: strobes are exclusive
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));

  // R2
  rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !wr_stb && !addr_ld && addr_cur != 4'hF) |=> addr_cur == $past(addr_cur) + 4'd1);

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !wr_stb && !addr_ld && addr_cur == 4'hF) |=> $stable(addr_cur));

  // R3
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !addr_ld && !wr_hold) |=> addr_cur == $past(addr_cur) + 4'd1);

  // R3
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !addr_ld && wr_hold) |=> $stable(addr_cur));

  // R4
  ld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ld |=> addr_cur == $past(addr_in));

  // R7
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> xfer_active);

  // R6
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && addr_cur == 4'd1 && !wd_xen) |=> !xfer_active);

  // R11
  srst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && addr_cur == 4'd15) |=> (!xfer_active && ifctl_out == 8'h00));
endmodule

bind sector_ctl_regfile sctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_in(addr_in),
  .rd_stb(rd_stb), .wr_stb(wr_stb), .wd_xen(wr_data[1]),
  .addr_cur(addr_cur), .xfer_active(xfer_active), .xfer_start(xfer_start),
  .ifctl_out(ifctl_out)
);

// File: tb/tb_sector_ctl_regfile.sv
`timescale 1ns/1ps
module tb_sector_ctl_regfile;
  logic clk = 1'b0;
  logic rst_n;
  logic addr_ld, rd_stb, wr_stb;
  logic [3:0] addr_in, addr_cur;
  logic [7:0] wr_data, rd_data, sub_hdr, ifctl_out;
  logic xfer_active, xfer_start;
  logic [15:0] dma_addr;
  logic [23:0] ctl_word;

  always #2 clk = ~clk;

  sector_ctl_regfile dut (
    .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_in(addr_in),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data),
    .addr_cur(addr_cur), .xfer_active(xfer_active), .xfer_start(xfer_start),
    .dma_addr(dma_addr), .sub_hdr(sub_hdr), .ctl_word(ctl_word), .ifctl_out(ifctl_out)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  localparam logic [15:0] TRK = 16'h73F2;

  // reference state
  logic [3:0]  m_addr;
  logic [7:0]  m_ifst, m_ifctl, m_ctl0, m_ctl1, m_ctl2, m_sbo, m_stat3;
  logic [15:0] m_dbc, m_dac, m_wa, m_pt, m_mask;
  logic        m_act;

  task automatic m_reset();
    m_ifst = 8'hFF; m_ifctl = 0; m_ctl0 = 0; m_ctl1 = 0; m_ctl2 = 0; m_sbo = 0;
    m_stat3 = 0; m_dbc = 0; m_dac = 0; m_wa = 16'd4704; m_pt = 0; m_mask = 0; m_act = 0;
  endtask

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    case (a)
      4'd1:  return m_ifst;
      4'd2:  return m_dbc[7:0];
      4'd3:  return m_dbc[15:8];
      4'd7:  return 8'h01;
      4'd8:  return m_pt[7:0];
      4'd9:  return m_pt[15:8];
      4'd10: return m_wa[7:0];
      4'd11: return m_wa[15:8];
      4'd12: return 8'h80;
      4'd15: return m_stat3;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_ld(input logic [3:0] a);
    @(negedge clk); addr_ld = 1'b1; addr_in = a;
    @(negedge clk); addr_ld = 1'b0;
    m_addr = a;
    chk("R4 index load", addr_cur, a);
  endtask

  task automatic do_rd(input string tag);
    logic [3:0] a;
    a = m_addr;
    @(negedge clk); rd_stb = 1'b1;
    #1 chk(tag, rd_data, exp_rd(a));
    @(negedge clk); rd_stb = 1'b0;
    if (TRK[a]) m_mask[a] = 1'b1;
    if (a == 4'd15) begin
      m_ifst[5] = 1'b1;
      if (m_ctl0[7] && m_ifctl[5] && ((m_mask & TRK) == TRK)) m_stat3 = 8'h80;
    end else m_addr = a + 4'd1;
    chk("R2 read step", addr_cur, m_addr);
  endtask

  task automatic do_wr(input logic [7:0] d);
    logic [3:0] a;
    a = m_addr;
    @(negedge clk); wr_stb = 1'b1; wr_data = d;
    #1 chk("R7 start pulse", xfer_start, (a == 4'd6) && m_ifctl[1]);
    @(negedge clk); wr_stb = 1'b0;
    case (a)
      4'd0:  m_sbo = d;
      4'd1:  begin m_ifctl = d; if (!d[1]) begin m_dbc = 0; m_act = 0; m_ifst[3] = 1'b1; end end
      4'd2:  m_dbc[7:0] = d;
      4'd3:  m_dbc[15:8] = d;
      4'd4:  m_dac[7:0] = d;
      4'd5:  m_dac[15:8] = d;
      4'd6:  if (m_ifctl[1]) begin m_ifst[3] = 1'b0; m_act = 1'b1; end
      4'd7:  m_ifst[6] = 1'b1;
      4'd8:  m_wa[7:0] = d;
      4'd9:  m_wa[15:8] = d;
      4'd10: m_ctl0 = d;
      4'd11: m_ctl1 = d;
      4'd12: m_pt[7:0] = d;
      4'd13: m_pt[15:8] = d;
      4'd14: m_ctl2 = d;
      default: m_reset();
    endcase
    if (!(a == 4'd6 || a == 4'd7 || a == 4'd14 || a == 4'd15)) m_addr = a + 4'd1;
    chk("R3 write step", addr_cur, m_addr);
    chk("R6 R7 R11 active flag", xfer_active, m_act);
    chk("R12 dma address", dma_addr, m_dac);
    chk("R12 subheader", sub_hdr, m_sbo);
    chk("R12 control word", ctl_word, {m_ctl2, m_ctl1, m_ctl0});
    chk("R12 interface control", ifctl_out, m_ifctl);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; addr_ld = 0; rd_stb = 0; wr_stb = 0; addr_in = 0; wr_data = 0;
    m_reset(); m_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset index", addr_cur, 4'd0);
    chk("R1 reset active", xfer_active, 1'b0);
    chk("R1 reset ctl", ctl_word, 24'h0);
    for (int i = 0; i < 16; i++) do_rd("R1 R5 reset sweep");

    // R5 byte count, write address and pointer round trip
    do_ld(4'd2); do_wr(8'h34); do_wr(8'h12);
    do_ld(4'd8); do_wr(8'h55); do_wr(8'hAA);
    do_ld(4'd12); do_wr(8'h9C); do_wr(8'h07);
    do_ld(4'd2); do_rd("R5 count lo"); do_rd("R5 count hi");
    do_ld(4'd8); do_rd("R5 pointer lo"); do_rd("R5 pointer hi");
    do_rd("R5 waddr lo"); do_rd("R5 waddr hi");

    // R12 write-only registers
    do_ld(4'd0); do_wr(8'hC3);
    do_ld(4'd4); do_wr(8'h11); do_wr(8'h22);
    do_ld(4'd10); do_wr(8'h5A); do_wr(8'hA5);
    do_ld(4'd14); do_wr(8'h3C);

    // R7 trigger disabled has no effect
    do_ld(4'd6); do_wr(8'h00);
    do_ld(4'd1); do_rd("R7 idle bit stays set");
    // R7 enabled trigger
    do_ld(4'd1); do_wr(8'h02);
    do_ld(4'd6); do_wr(8'hFF);
    chk("R7 index held on trigger", addr_cur, 4'd6);
    do_ld(4'd1); do_rd("R7 idle bit cleared");
    // R8 acknowledge
    do_ld(4'd7); do_wr(8'h00);
    chk("R8 index held on ack", addr_cur, 4'd7);
    do_ld(4'd1); do_rd("R8 end flag set");
    // R6 stop
    do_ld(4'd2); do_wr(8'h77);
    do_ld(4'd1); do_wr(8'h00);
    do_ld(4'd1); do_rd("R6 idle bit set"); do_rd("R6 count cleared");

    // R10 interlock with one tracked register missing
    do_ld(4'd15); do_wr(8'h00);
    do_ld(4'd10); do_wr(8'h80);
    do_ld(4'd1); do_wr(8'h22);
    do_ld(4'd1); do_rd("R9 tracked read");
    do_ld(4'd4); for (int i = 0; i < 6; i++) do_rd("R9 tracked read");
    do_ld(4'd12); do_rd("R9 tracked read"); do_rd("R9 tracked read");
    do_ld(4'd15); do_rd("R10 status3 not armed"); do_rd("R10 status3 not armed");
    do_ld(4'd14); do_rd("R9 tracked read");
    do_rd("R10 old status3 returned"); do_rd("R10 status3 armed");
    do_ld(4'd1); do_rd("R9 decode flag set");

    // R11 soft reset restores everything
    do_ld(4'd15); do_wr(8'h5E);
    chk("R11 index held", addr_cur, 4'd15);
    do_ld(4'd0);
    for (int i = 0; i < 16; i++) do_rd("R11 post reset sweep");

    // random traffic
    void'($urandom(32'd20240611));
    for (int n = 0; n < 600; n++) begin
      int unsigned op;
      op = $urandom % 8;
      if (op == 0)      do_ld(4'($urandom % 16));
      else if (op < 4)  do_rd("R5 random read");
      else              do_wr(8'($urandom % 256));
    end

    finish_run();
  end
endmodule